// File: doc/BRIEF.md
# Channel Address and Frame Counter

This block generates the addresses and tracks the progress of one DMA channel. A load pulse captures a source and a destination start address, a stride for each side, a frame length in bytes, a frame count and a 32-bit mode word. From the mode word it uses two 2-bit fields that pick how each pointer moves. Each accepted 32-bit beat then moves both pointers and takes four bytes off the remaining byte count of the current frame. When a frame ends, the byte count reloads and the frame count drops by one.

Each side moves on its own. A pointer can stay fixed, step by four bytes, or step by four within a frame and jump to its frame start plus its stride at each frame boundary. Single-cycle event pulses report four things: a frame passing its half-way point, a frame ending, the last frame being entered, and the whole block ending. The channel controller steers the bus with the exposed pointers and counts, and routes the events to its interrupt logic.

Top module: `chan_addr_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `active`, both pointers, both remaining counts and `evt` are all zero.
- R2: One cycle after `load`, the pointers equal the start addresses, `remain_bytes` equals the frame length and `remain_frames` equals the frame count. `active` is 1 when both the length and the count are nonzero. A `load` while active restarts the channel and discards its progress.
- R3: A pointer whose mode field is 1 steps by +4 on every accepted beat, across frame boundaries too. The source field is `cfg_mode[17:16]` and the destination field is `cfg_mode[19:18]`.
- R4: A pointer whose mode field is 0 or 3 does not change on beats.
- R5: A pointer whose mode field is 2 steps by +4 within a frame. On the beat that ends a frame it moves to that frame's start address plus its stride, and this becomes the start address of the next frame.
- R6: Each accepted beat lowers `remain_bytes` by 4, or to 0 when 4 or fewer bytes remain. That beat ends the frame. When further frames remain, the same edge reloads `remain_bytes` with the frame length and lowers `remain_frames` by 1.
- R7: `evt[2]` pulses for one cycle after the beat that ends each frame.
- R8: `evt[3]` pulses once per frame, after the first beat that leaves `remain_bytes` at or below floor(frame length / 2).
- R9: `evt[4]` pulses once when the last frame is entered. This happens one cycle after a `load` with a frame count of 1, or after the end of the second-to-last frame.
- R10: After the beat that ends the final frame, `evt[0]` and `evt[1]` pulse together with `evt[2]`. On the same edge `active` drops and `remain_frames` becomes 0.
- R11: A `load` with a frame length of 0 or a frame count of 0 leaves `active` at 0 and produces `evt` = 5'b00111 in the next cycle.
- R12: `beat` has no effect while `active` is 0: the pointers and counts hold and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture the configuration and start |
| cfg_mode | input | 32 | Mode word; [17:16] source mode, [19:18] destination mode |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_src_stride | input | 32 | Source stride applied at frame ends |
| cfg_dst_stride | input | 32 | Destination stride applied at frame ends |
| cfg_frame_len | input | 20 | Frame length in bytes |
| cfg_frame_cnt | input | 12 | Number of frames |
| beat | input | 1 | A 32-bit data beat was accepted this cycle |
| active | output | 1 | A transfer is in progress |
| cur_src | output | 32 | Current source pointer |
| cur_dst | output | 32 | Current destination pointer |
| remain_bytes | output | 20 | Bytes left in the current frame |
| remain_frames | output | 12 | Frames left, including the current one |
| evt | output | 5 | Event pulses: 0 block, 1 super block, 2 frame, 3 half frame, 4 last frame |

## Verification
Every output is a register, so the effect of a `load` or a `beat` sampled at one rising edge is visible from that edge until the next. An event pulse therefore sits exactly in the cycle after its cause. The bench drives inputs and samples outputs on the falling edge. After a stimulus held for n rising edges it checks at the falling edge that follows, which makes pointers and counts reflect exactly n beats. Events are checked one beat at a time, so each pulse is compared in the single cycle where it is due and seen to be gone in the next.

// File: rtl/cae_pkg.sv
package cae_pkg;

  typedef enum logic [1:0] {
    AM_FIXED  = 2'd0,
    AM_INCR   = 2'd1,
    AM_STRIDE = 2'd2,
    AM_RSVD   = 2'd3
  } addr_mode_e;

  // Mode word field positions decoded by this block
  localparam int SRC_MODE_LSB = 16;
  localparam int MODE_FLD_W   = 2;

  // Event vector bit positions
  localparam int EV_BLOCK = 0;
  localparam int EV_SUPER = 1;
  localparam int EV_FRAME = 2;
  localparam int EV_HALF  = 3;
  localparam int EV_LAST  = 4;
  localparam int EV_W     = 5;

endpackage

// File: rtl/cae_frame_ctr.sv
module cae_frame_ctr
  import cae_pkg::*;
#(
  parameter int FLEN_W     = 20,
  parameter int FCNT_W     = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FLEN_W-1:0] cfg_len,
  input  logic [FCNT_W-1:0] cfg_cnt,
  input  logic              beat,
  output logic              active,
  output logic              step,
  output logic              frame_end,
  output logic [FLEN_W-1:0] remain_bytes,
  output logic [FCNT_W-1:0] remain_frames,
  output logic [EV_W-1:0]   evt
);

  localparam logic [FLEN_W-1:0] STEP_B = FLEN_W'(BEAT_BYTES);

  logic              act_q, act_d;
  logic [FLEN_W-1:0] len_q, len_d;
  logic [FLEN_W-1:0] rem_q, rem_d;
  logic [FCNT_W-1:0] frm_q, frm_d;
  logic              half_q, half_d;
  logic [EV_W-1:0]   evt_q, evt_d;
  logic              last_beat;
  logic [FLEN_W-1:0] rem_dec;
  logic              en;

  assign step      = beat & act_q & ~load;
  assign last_beat = (rem_q <= STEP_B);
  assign rem_dec   = last_beat ? '0 : rem_q - STEP_B;
  assign frame_end = step & last_beat;
  assign en        = load | step;

  always_comb begin
    act_d  = act_q;
    len_d  = len_q;
    rem_d  = rem_q;
    frm_d  = frm_q;
    half_d = half_q;
    evt_d  = '0;
    if (load) begin
      len_d  = cfg_len;
      rem_d  = cfg_len;
      frm_d  = cfg_cnt;
      half_d = 1'b0;
      if (cfg_len == '0 || cfg_cnt == '0) begin
        act_d           = 1'b0;
        evt_d[EV_BLOCK] = 1'b1;
        evt_d[EV_SUPER] = 1'b1;
        evt_d[EV_FRAME] = 1'b1;
      end else begin
        act_d          = 1'b1;
        evt_d[EV_LAST] = (cfg_cnt == FCNT_W'(1));
      end
    end else if (step) begin
      rem_d = rem_dec;
      if (!half_q && rem_dec <= (len_q >> 1)) begin
        evt_d[EV_HALF] = 1'b1;
        half_d         = 1'b1;
      end
      if (last_beat) begin
        evt_d[EV_FRAME] = 1'b1;
        if (frm_q == FCNT_W'(1)) begin
          frm_d           = '0;
          act_d           = 1'b0;
          evt_d[EV_BLOCK] = 1'b1;
          evt_d[EV_SUPER] = 1'b1;
        end else begin
          frm_d          = frm_q - FCNT_W'(1);
          rem_d          = len_q;
          half_d         = 1'b0;
          evt_d[EV_LAST] = (frm_q == FCNT_W'(2));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      len_q  <= '0;
      rem_q  <= '0;
      frm_q  <= '0;
      half_q <= 1'b0;
    end else if (en) begin
      act_q  <= act_d;
      len_q  <= len_d;
      rem_q  <= rem_d;
      frm_q  <= frm_d;
      half_q <= half_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign active        = act_q;
  assign remain_bytes  = rem_q;
  assign remain_frames = frm_q;
  assign evt           = evt_q;

endmodule

// File: rtl/cae_ptr_gen.sv
module cae_ptr_gen
  import cae_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_stride,
  input  logic [1:0]    cfg_mode,
  input  logic          step,
  input  logic          frame_end,
  output logic [AW-1:0] cur_addr
);

  localparam logic [AW-1:0] STEP_A = AW'(BEAT_BYTES);

  addr_mode_e    mode_q, mode_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] strd_q, strd_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    mode_d = mode_q;
    base_d = base_q;
    strd_d = strd_q;
    ptr_d  = ptr_q;
    if (load) begin
      mode_d = addr_mode_e'(cfg_mode);
      base_d = cfg_addr;
      strd_d = cfg_stride;
      ptr_d  = cfg_addr;
    end else if (step) begin
      case (mode_q)
        AM_INCR: ptr_d = ptr_q + STEP_A;
        AM_STRIDE: begin
          if (frame_end) begin
            base_d = base_q + strd_q;
            ptr_d  = base_q + strd_q;
          end else begin
            ptr_d  = ptr_q + STEP_A;
          end
        end
        default: ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_FIXED;
      base_q <= '0;
      strd_q <= '0;
      ptr_q  <= '0;
    end else if (en) begin
      mode_q <= mode_d;
      base_q <= base_d;
      strd_q <= strd_d;
      ptr_q  <= ptr_d;
    end
  end

  assign cur_addr = ptr_q;

endmodule

// File: rtl/chan_addr_engine.sv
module chan_addr_engine
  import cae_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MODE_W     = 32,
  parameter int FLEN_W     = 20,
  parameter int FCNT_W     = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [AW-1:0]     cfg_src_addr,
  input  logic [AW-1:0]     cfg_dst_addr,
  input  logic [AW-1:0]     cfg_src_stride,
  input  logic [AW-1:0]     cfg_dst_stride,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  input  logic [FCNT_W-1:0] cfg_frame_cnt,
  input  logic              beat,
  output logic              active,
  output logic [AW-1:0]     cur_src,
  output logic [AW-1:0]     cur_dst,
  output logic [FLEN_W-1:0] remain_bytes,
  output logic [FCNT_W-1:0] remain_frames,
  output logic [EV_W-1:0]   evt
);

  localparam int NSIDE = 2;

  logic          step;
  logic          frame_end;
  logic [AW-1:0] side_addr   [NSIDE];
  logic [AW-1:0] side_stride [NSIDE];
  logic [AW-1:0] side_ptr    [NSIDE];
  logic          unused_mode_bits;

  // Bits of the mode word outside the two address-mode fields are decoded elsewhere
  assign unused_mode_bits = ^cfg_mode;

  assign side_addr[0]   = cfg_src_addr;
  assign side_addr[1]   = cfg_dst_addr;
  assign side_stride[0] = cfg_src_stride;
  assign side_stride[1] = cfg_dst_stride;

  cae_frame_ctr #(
    .FLEN_W    (FLEN_W),
    .FCNT_W    (FCNT_W),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .cfg_len      (cfg_frame_len),
    .cfg_cnt      (cfg_frame_cnt),
    .beat         (beat),
    .active       (active),
    .step         (step),
    .frame_end    (frame_end),
    .remain_bytes (remain_bytes),
    .remain_frames(remain_frames),
    .evt          (evt)
  );

  // Side 0 = source (mode field at 17:16), side 1 = destination (19:18)
  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    cae_ptr_gen #(
      .AW        (AW),
      .BEAT_BYTES(BEAT_BYTES)
    ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .cfg_addr  (side_addr[g]),
      .cfg_stride(side_stride[g]),
      .cfg_mode  (cfg_mode[SRC_MODE_LSB + MODE_FLD_W*g +: MODE_FLD_W]),
      .step      (step),
      .frame_end (frame_end),
      .cur_addr  (side_ptr[g])
    );
  end

  assign cur_src = side_ptr[0];
  assign cur_dst = side_ptr[1];

endmodule

// File: rtl/cae_checker.sv
module cae_checker #(
  parameter int AW     = 32,
  parameter int FLEN_W = 20,
  parameter int FCNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              beat,
  input logic [FCNT_W-1:0] cfg_frame_cnt,
  input logic              active,
  input logic [AW-1:0]     cur_src,
  input logic [AW-1:0]     cur_dst,
  input logic [FLEN_W-1:0] remain_bytes,
  input logic [FCNT_W-1:0] remain_frames,
  input logic [4:0]        evt
);

  // R2
  load_captures_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain_frames == $past(cfg_frame_cnt));

  // R6
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && beat && !load && remain_bytes > FLEN_W'(4))
      |=> remain_bytes == $past(remain_bytes) - FLEN_W'(4));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> ($stable(cur_src) && $stable(cur_dst) &&
                            $stable(remain_bytes) && $stable(remain_frames)));

  // R10
  stop_with_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> evt[0]);

  // R10
  block_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> (evt[1] && evt[2]));

  // R9
  last_frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[4] |-> remain_frames == FCNT_W'(1));

  // R8
  half_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[3] |-> ($past(active) && $past(beat)));

endmodule

bind chan_addr_engine cae_checker #(
  .AW    (AW),
  .FLEN_W(FLEN_W),
  .FCNT_W(FCNT_W)
) u_cae_checker (.*);

// File: tb/tb_chan_addr_engine.sv
`timescale 1ns/1ps
module tb_chan_addr_engine;

  logic        clk;
  logic        rst_n;
  logic        load;
  logic [31:0] cfg_mode;
  logic [31:0] cfg_src_addr, cfg_dst_addr, cfg_src_stride, cfg_dst_stride;
  logic [19:0] cfg_frame_len;
  logic [11:0] cfg_frame_cnt;
  logic        beat;
  logic        active;
  logic [31:0] cur_src, cur_dst;
  logic [19:0] remain_bytes;
  logic [11:0] remain_frames;
  logic [4:0]  evt;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  chan_addr_engine dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [19:0] len;
    logic [11:0] cnt;
    logic [31:0] stride;
    logic [7:0]  nb;
    logic [31:0] e_src;
    logic [31:0] e_dst;
    logic [19:0] e_rb;
    logic [11:0] e_rf;
    logic        e_act;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VT [NV] = '{
    '{2'd1, 2'd0, 20'd16, 12'd2, 32'h100, 8'd3, 32'h100C, 32'h2000, 20'd4, 12'd2, 1'b1},
    '{2'd2, 2'd1, 20'd8,  12'd3, 32'h100, 8'd2, 32'h1100, 32'h2008, 20'd8, 12'd2, 1'b1},
    '{2'd0, 2'd2, 20'd8,  12'd3, 32'h40,  8'd5, 32'h1000, 32'h2084, 20'd4, 12'd1, 1'b1},
    '{2'd3, 2'd1, 20'd6,  12'd1, 32'h0,   8'd1, 32'h1000, 32'h2004, 20'd2, 12'd1, 1'b1},
    '{2'd1, 2'd1, 20'd6,  12'd1, 32'h0,   8'd2, 32'h1008, 32'h2008, 20'd0, 12'd0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] sm, input logic [1:0] dm, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] stride,
                         input logic [19:0] len, input logic [11:0] cnt);
    cfg_mode       = {12'h0, dm, sm, 16'h0};
    cfg_src_addr   = src;
    cfg_dst_addr   = dst;
    cfg_src_stride = stride;
    cfg_dst_stride = stride;
    cfg_frame_len  = len;
    cfg_frame_cnt  = cnt;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic beats(input int n);
    beat = 1'b1;
    repeat (n) @(negedge clk);
    beat = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; beat = 1'b0;
    cfg_mode = '0; cfg_src_addr = '0; cfg_dst_addr = '0;
    cfg_src_stride = '0; cfg_dst_stride = '0; cfg_frame_len = '0; cfg_frame_cnt = '0;
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk("R1 active", 32'(active), 32'd0);
    chk("R1 cur_src", cur_src, 32'd0);
    chk("R1 remain_frames", 32'(remain_frames), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 evt", 32'(evt), 32'd0);
    chk("R1 remain_bytes", 32'(remain_bytes), 32'd0);

    // Table: R3/R4/R5 pointer modes, R6 counts, R2 load values
    for (int i = 0; i < NV; i++) begin
      do_load(VT[i].sm, VT[i].dm, 32'h1000, 32'h2000, VT[i].stride, VT[i].len, VT[i].cnt);
      chk("R2 load src", cur_src, 32'h1000);
      chk("R2 load remain_bytes", 32'(remain_bytes), 32'(VT[i].len));
      beats(int'(VT[i].nb));
      chk("R3/R4/R5 src pointer", cur_src, VT[i].e_src);
      chk("R3/R4/R5 dst pointer", cur_dst, VT[i].e_dst);
      chk("R6 remain_bytes", 32'(remain_bytes), 32'(VT[i].e_rb));
      chk("R6 remain_frames", 32'(remain_frames), 32'(VT[i].e_rf));
      chk("R10 active", 32'(active), 32'(VT[i].e_act));
    end

    // R8, R7, R9, R10 event sequence: len 16, two frames
    do_load(2'd1, 2'd1, 32'h1000, 32'h2000, 32'h0, 20'd16, 12'd2);
    chk("R9 no last on cnt 2", 32'(evt), 32'h00);
    beats(1); chk("R8 no half above midpoint", 32'(evt), 32'h00);
    chk("R6 first beat", 32'(remain_bytes), 32'd12);
    beats(1); chk("R8 half at midpoint", 32'(evt), 32'h08);
    beats(1); chk("R8 half only once", 32'(evt), 32'h00);
    beats(1); chk("R7 R9 frame end enters last", 32'(evt), 32'h14);
    chk("R6 reload bytes", 32'(remain_bytes), 32'd16);
    chk("R6 frames down", 32'(remain_frames), 32'd1);
    beats(1); chk("R8 second frame quiet", 32'(evt), 32'h00);
    beats(1); chk("R8 half second frame", 32'(evt), 32'h08);
    beats(1); chk("R7 mid frame", 32'(evt), 32'h00);
    beats(1); chk("R10 block end events", 32'(evt), 32'h07);
    chk("R10 active low", 32'(active), 32'd0);
    chk("R10 frames zero", 32'(remain_frames), 32'd0);
    chk("R3 src across frames", cur_src, 32'h1020);
    @(negedge clk); chk("R7 pulse single cycle", 32'(evt), 32'h00);

    // R12 beats while idle
    beats(3);
    chk("R12 src held", cur_src, 32'h1020);
    chk("R12 dst held", cur_dst, 32'h2020);
    chk("R12 bytes held", 32'(remain_bytes), 32'd0);
    chk("R12 no event", 32'(evt), 32'h00);

    // R11 zero length and zero count
    do_load(2'd1, 2'd1, 32'h1000, 32'h2000, 32'h0, 20'd0, 12'd3);
    chk("R11 zero len evt", 32'(evt), 32'h07);
    chk("R11 zero len idle", 32'(active), 32'd0);
    do_load(2'd1, 2'd1, 32'h1000, 32'h2000, 32'h0, 20'd8, 12'd0);
    chk("R11 zero cnt evt", 32'(evt), 32'h07);
    chk("R11 zero cnt idle", 32'(active), 32'd0);

    // R9 single frame load
    do_load(2'd1, 2'd1, 32'h1000, 32'h2000, 32'h0, 20'd8, 12'd1);
    chk("R9 last on load", 32'(evt), 32'h10);
    chk("R2 active", 32'(active), 32'd1);

    // R2 restart while active
    beats(1);
    do_load(2'd1, 2'd0, 32'h3000, 32'h4000, 32'h0, 20'd12, 12'd4);
    chk("R2 restart src", cur_src, 32'h3000);
    chk("R2 restart bytes", 32'(remain_bytes), 32'd12);
    chk("R2 restart frames", 32'(remain_frames), 32'd4);
    chk("R2 restart no event", 32'(evt), 32'h00);

    // R8 one-beat frame: half, frame and last together
    do_load(2'd1, 2'd1, 32'h1000, 32'h2000, 32'h0, 20'd4, 12'd2);
    beats(1);
    chk("R8 R7 R9 one-beat frame", 32'(evt), 32'h1C);
    chk("R6 one-beat reload", 32'(remain_bytes), 32'd4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule